// File: doc/BRIEF.md
# Dynamic Priority Interrupt Resolver

This block picks one winning interrupt line out of a set of request lines. The lines are grouped in banks of 32. It sees a pending vector, a mask vector, a class-steering vector and a priority value for every line. A select input chooses which class is being resolved: the normal interrupt class or the fast interrupt class. A line can win only if three things hold: it is pending, it is not masked, and it is steered to the selected class. Among those lines, the one with the numerically smallest priority wins. When several lines share that best value, the highest-numbered line wins.

The resolver works sequentially. A one-cycle start pulse begins a scan that visits one line per clock, from line 0 upward. A one-cycle done pulse then presents a registered line code and a valid flag. The code equals the bank index times 32 plus the bit position in the bank, which is simply the flat line number. The code and the flag hold until the next scan finishes. The controller samples the request vectors during the scan, so it must keep them steady from start to done. A parameter can shrink the priority field that the block uses, so that priority bits above it play no part in the decision.

Top module: `irq_resolver`

## Requirements
- R1: After reset, done, valid and code are all 0.
- R2: Line n (bit n of each vector) is eligible only when pend[n]=1, mask[n]=0 and steer[n] equals fiq_sel (steer 1 = fast class, 0 = normal class).
- R3: Among eligible lines, the one with the numerically lowest priority value (prio[n*PRIO_W +: PRIO_W]) wins; 0 is the most urgent.
- R4: When several eligible lines share the best priority, the line with the highest line number wins.
- R5: The reported code is 32 * bank + bit position, which equals the flat line number n, and is below NUM_BANKS*32 whenever valid is 1.
- R6: When no line is eligible, done brings valid=0 and code=0.
- R7: done is a single-cycle pulse that rises NUM_BANKS*32 clock edges after the edge at which start is sampled.
- R8: A start pulse that arrives while a scan is in progress is ignored and does not move the done pulse.
- R9: valid and code change only together with done and hold their value until the next done.
- R10: With PRIO_USED below PRIO_W, the priority bits at and above PRIO_USED are ignored in the comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a scan |
| fiq_sel | input | 1 | Class to resolve: 1 fast, 0 normal |
| pend | input | NUM_BANKS*32 | Pending bit per line |
| mask | input | NUM_BANKS*32 | Mask bit per line, 1 blocks the line |
| steer | input | NUM_BANKS*32 | Class steering bit per line |
| prio | input | NUM_BANKS*32*PRIO_W | Priority value per line, line n at n*PRIO_W |
| done | output | 1 | One-cycle pulse when the result is ready |
| valid | output | 1 | An eligible line was found |
| code | output | clog2(NUM_BANKS*32) | Winning line number, 0 if none |

## Verification
Random vectors use a narrow priority range, so that ties are common and the highest-line rule gets tested. They also use a full-width range, which tests the lower-value-wins ordering. Pending, mask and steering densities vary, and both classes are resolved. These runs separate a scan that ignores the mask or the class from one that honours them. Directed cases cover the following: a fully masked set, all lines tied at one value, a single urgent line at each end of the range, and a start pulse in mid-scan. A second instance with a narrowed priority field gets the same inputs, with top bits set that would change the winner if they were used.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    // Worst-case starting value for the running best priority.
    localparam int unsigned BEST_W    = 8;
    localparam logic [BEST_W-1:0] BEST_INIT = 8'd255;

endpackage

// File: rtl/irq_line_pick.sv
module irq_line_pick #(
    parameter int unsigned NUM_BANKS  = 3,
    parameter int unsigned BANK_LINES = 32,
    parameter int unsigned PRIO_W     = 6,
    parameter int unsigned PRIO_USED  = 6,
    localparam int unsigned NUM_LINES = NUM_BANKS * BANK_LINES,
    localparam int unsigned IDX_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]        pend,
    input  logic [NUM_LINES-1:0]        mask,
    input  logic [NUM_LINES-1:0]        steer,
    input  logic [NUM_LINES*PRIO_W-1:0] prio,
    input  logic                        fiq_sel,
    input  logic [IDX_W-1:0]            idx,
    output logic                        eligible,
    output logic [PRIO_W-1:0]           prio_sel
);

    logic [NUM_BANKS-1:0] bank_hit;
    logic [NUM_BANKS-1:0] bank_elig;
    logic [PRIO_W-1:0]    bank_prio [NUM_BANKS];
    logic [PRIO_W-1:0]    raw_prio;

    // One slice per bank: each bank resolves the selected line locally.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_LINES-1:0]        b_pend;
        logic [BANK_LINES-1:0]        b_mask;
        logic [BANK_LINES-1:0]        b_steer;
        logic [BANK_LINES*PRIO_W-1:0] b_prio;

        assign b_pend  = pend [b*BANK_LINES +: BANK_LINES];
        assign b_mask  = mask [b*BANK_LINES +: BANK_LINES];
        assign b_steer = steer[b*BANK_LINES +: BANK_LINES];
        assign b_prio  = prio [b*BANK_LINES*PRIO_W +: BANK_LINES*PRIO_W];

        always_comb begin
            bank_hit[b]  = 1'b0;
            bank_elig[b] = 1'b0;
            bank_prio[b] = '0;
            for (int i = 0; i < BANK_LINES; i++) begin
                if (idx == IDX_W'(b*BANK_LINES + i)) begin
                    bank_hit[b]  = 1'b1;
                    bank_elig[b] = b_pend[i] & ~b_mask[i] & (b_steer[i] == fiq_sel);
                    bank_prio[b] = b_prio[i*PRIO_W +: PRIO_W];
                end
            end
        end
    end

    always_comb begin
        eligible = 1'b0;
        raw_prio = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                eligible = bank_elig[b];
                raw_prio = bank_prio[b];
            end
        end
    end

    // Optional narrowing of the priority field.
    if (PRIO_USED < PRIO_W) begin : g_narrow
        assign prio_sel = {{(PRIO_W-PRIO_USED){1'b0}}, raw_prio[PRIO_USED-1:0]};
    end else begin : g_full
        assign prio_sel = raw_prio;
    end

endmodule

// File: rtl/irq_prio_cmp.sv
module irq_prio_cmp #(
    parameter int unsigned PRIO_W = 6,
    parameter int unsigned BEST_W = 8
) (
    input  logic              eligible,
    input  logic [PRIO_W-1:0] prio_sel,
    input  logic [BEST_W-1:0] best,
    output logic              take,
    output logic [BEST_W-1:0] prio_ext
);

    assign prio_ext = {{(BEST_W-PRIO_W){1'b0}}, prio_sel};
    // Less-or-equal lets a later (higher-numbered) line win a tie.
    assign take     = eligible && (prio_ext <= best);

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
    parameter int unsigned NUM_BANKS  = 3,
    parameter int unsigned BANK_LINES = 32,
    parameter int unsigned PRIO_W     = 6,
    parameter int unsigned PRIO_USED  = 6,
    localparam int unsigned NUM_LINES = NUM_BANKS * BANK_LINES,
    localparam int unsigned IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        fiq_sel,
    input  logic [NUM_LINES-1:0]        pend,
    input  logic [NUM_LINES-1:0]        mask,
    input  logic [NUM_LINES-1:0]        steer,
    input  logic [NUM_LINES*PRIO_W-1:0] prio,
    output logic                        done,
    output logic                        valid,
    output logic [IDX_W-1:0]            code
);
    import irq_res_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [BEST_W-1:0] best;
        logic              found;
        logic [IDX_W-1:0]  cand;
        logic              done;
        logic              valid;
        logic [IDX_W-1:0]  code;
    } res_state_t;

    res_state_t st_d, st_q;

    logic              line_elig;
    logic [PRIO_W-1:0] line_prio;
    logic              take;
    logic [BEST_W-1:0] line_prio_ext;
    logic              scan_active;

    irq_line_pick #(
        .NUM_BANKS  (NUM_BANKS),
        .BANK_LINES (BANK_LINES),
        .PRIO_W     (PRIO_W),
        .PRIO_USED  (PRIO_USED)
    ) u_pick (
        .pend     (pend),
        .mask     (mask),
        .steer    (steer),
        .prio     (prio),
        .fiq_sel  (fiq_sel),
        .idx      (st_q.idx),
        .eligible (line_elig),
        .prio_sel (line_prio)
    );

    irq_prio_cmp #(
        .PRIO_W (PRIO_W),
        .BEST_W (BEST_W)
    ) u_cmp (
        .eligible (line_elig),
        .prio_sel (line_prio),
        .best     (st_q.best),
        .take     (take),
        .prio_ext (line_prio_ext)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.idx   = '0;
                st_d.best  = BEST_INIT;
                st_d.found = 1'b0;
                st_d.cand  = '0;
            end
        end else begin
            if (take) begin
                st_d.best  = line_prio_ext;
                st_d.cand  = st_q.idx;
                st_d.found = 1'b1;
            end
            if (st_q.idx == LAST_IDX) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.valid = st_q.found | take;
                st_d.code  = take ? st_q.idx : st_q.cand;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.best  <= BEST_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_active = st_q.busy;
    assign done        = st_q.done;
    assign valid       = st_q.valid;
    assign code        = st_q.code;

endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
    parameter int unsigned NUM_LINES = 96,
    parameter int unsigned IDX_W     = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 fiq_sel,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] mask,
    input logic [NUM_LINES-1:0] steer,
    input logic                 done,
    input logic                 valid,
    input logic [IDX_W-1:0]     code,
    input logic                 scan_active
);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    empty_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !valid) |-> (code == '0));

    // R2
    winner_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> (pend[code] && !mask[code] && (steer[code] == fiq_sel)));

    // R5
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> (code < IDX_W'(NUM_LINES)));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({valid, code}));

    // R8
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_active && start) |=> (scan_active || done));

endmodule

bind irq_resolver irq_resolver_chk #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .fiq_sel     (fiq_sel),
    .pend        (pend),
    .mask        (mask),
    .steer       (steer),
    .done        (done),
    .valid       (valid),
    .code        (code),
    .scan_active (scan_active)
);

// File: tb/sim_irq_resolver.sv
module sim_irq_resolver;
    localparam int CLK_P  = 10;
    localparam int NB     = 3;
    localparam int NL     = NB * 32;
    localparam int PW     = 6;
    localparam int CW     = $clog2(NL);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic fiq_sel = 1'b0;
    logic [NL-1:0]    pend = '0, mask = '1, steer = '0;
    logic [NL*PW-1:0] prio = '0;
    logic done0, valid0, done1, valid1;
    logic [CW-1:0] code0, code1;

    int vecs = 0;
    int miss = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_resolver #(.NUM_BANKS(NB), .PRIO_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .fiq_sel(fiq_sel),
        .pend(pend), .mask(mask), .steer(steer), .prio(prio),
        .done(done0), .valid(valid0), .code(code0));

    irq_resolver #(.NUM_BANKS(NB), .PRIO_W(PW), .PRIO_USED(5)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .fiq_sel(fiq_sel),
        .pend(pend), .mask(mask), .steer(steer), .prio(prio),
        .done(done1), .valid(valid1), .code(code1));

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            miss++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: lowest value wins, ties to the highest line, start at 255.
    function automatic void model(input int used, output int v, output int c);
        int best = 255;
        v = 0; c = 0;
        for (int n = 0; n < NL; n++) begin
            int p = int'(prio[n*PW +: PW]) & ((1 << used) - 1);
            if (pend[n] && !mask[n] && (steer[n] == fiq_sel) && p <= best) begin
                best = p; v = 1; c = n;
            end
        end
    endfunction

    // Runs one scan; optionally pulses start again mid-scan.
    task automatic scan(input string tag, input bit restart);
        int cnt, ev, ec, nv, nc;
        model(PW, ev, ec);
        model(5, nv, nc);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cnt = 1;
        while (!done0 && cnt < 300) begin
            if (restart && cnt == 10) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        // R7 R8: done seen at the negedge after edge E0+NL, i.e. cnt == NL+1
        chk({tag, " R7 latency"}, cnt, NL + 1);
        chk({tag, " R2 R3 R4 valid"}, int'(valid0), ev);
        chk({tag, " R5 code"}, int'(code0), ec);
        chk({tag, " R10 narrow valid"}, int'(valid1), nv);
        chk({tag, " R10 narrow code"}, int'(code1), nc);
        @(negedge clk);
        chk({tag, " R7 single pulse"}, int'(done0), 0);
    endtask

    task automatic rand_fill(input int prange);
        for (int w = 0; w < NL/32; w++) begin
            pend[w*32 +: 32]  = $urandom | $urandom;
            mask[w*32 +: 32]  = $urandom & $urandom;
            steer[w*32 +: 32] = $urandom;
        end
        for (int n = 0; n < NL; n++) prio[n*PW +: PW] = PW'($urandom_range(prange, 0));
        fiq_sel = 1'($urandom);
    endtask

    initial begin
        #(CLK_P * 150000);
        miss++;
        $display("FAIL R7 watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        int sv, sc;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", int'(done0), 0);
        chk("R1 valid", int'(valid0), 0);
        chk("R1 code", int'(code0), 0);

        // R6: everything masked
        pend = '1; mask = '1; steer = '0; fiq_sel = 1'b0;
        scan("R6 all masked", 1'b0);
        chk("R6 code zero", int'(code0), 0);

        // R4: all lines tie at one value -> line NL-1
        mask = '0; prio = '0;
        scan("R4 full tie", 1'b0);
        chk("R4 top line", int'(code0), NL - 1);

        // R3: single urgent line 0, others worse
        for (int n = 0; n < NL; n++) prio[n*PW +: PW] = 6'd9;
        prio[0 +: PW] = 6'd2;
        scan("R3 line0 urgent", 1'b0);
        chk("R3 line0", int'(code0), 0);

        // R2: fast class with no steered lines -> nothing
        fiq_sel = 1'b1;
        scan("R2 no fast lines", 1'b0);
        steer[40] = 1'b1;
        scan("R2 one fast line", 1'b0);
        chk("R2 line40", int'(code0), 40);
        fiq_sel = 1'b0;

        // R10: top bit set on line 5 makes it worse in full mode only
        for (int n = 0; n < NL; n++) prio[n*PW +: PW] = 6'd20;
        prio[5*PW +: PW] = 6'h21;
        steer = '0;
        scan("R10 top bit", 1'b0);

        // R8: extra start mid-scan
        rand_fill(3);
        scan("R8 restart", 1'b1);

        // R9: change inputs after done, result holds
        sv = int'(valid0); sc = int'(code0);
        rand_fill(63);
        repeat (5) @(negedge clk);
        chk("R9 hold valid", int'(valid0), sv);
        chk("R9 hold code", int'(code0), sc);

        for (int k = 0; k < 60; k++) begin
            rand_fill((k % 2 == 0) ? 3 : 63);
            scan("random", 1'b0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule